// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes the state change a small in-order RISC core makes when it enters an exception handler. It samples the core's program counter, delay-slot flag and supervision register (SR), along with a synchronous exception request and its index and two level-sensitive interrupt lines: one for external devices and one for the tick timer. On the clock edge that accepts an entry, it registers several results. These are the saved exception PC, a copy of the old SR, the rewritten SR, a cleared delay-slot flag, the handler address and the cause index. It also pulses a taken strobe and a translation-cache flush strobe for one cycle each.

The saved PC depends on where the trapping instruction was. If the core was in a delay slot, the PC moves back one instruction slot, to the branch. A system call moves the PC forward one slot, so the handler returns past it. The handler address is the cause index shifted left by eight bits. A synchronous request with an index outside the defined range raises an error pulse and does not vector. In cycles with no entry, the SR and delay-slot outputs copy their inputs with one cycle of latency. The saved registers and the handler address keep their values.

Top module: `exc_entry`

## Requirements
- R1: On entry with no delay slot and a cause other than system call (index 12), `epc_o` equals the `pc_i` sampled at that edge.
- R2: On entry with `dslot_i` high, `epc_o` equals `pc_i` minus 4 (modulo 2^AW), SR bit 13 is set in `sr_o`, and `dslot_o` is 0.
- R3: On entry with cause index 12 (system call), 4 is added to the saved PC after any delay-slot adjustment. With a delay slot, `epc_o` therefore equals `pc_i`.
- R4: On entry, `esr_o` equals `sr_i` as sampled, before any bit is changed.
- R5: On entry, `sr_o` is `sr_i` with bit 0 (supervisor) set and bits 1 (tick enable), 2 (external enable), 5 (data translation) and 6 (instruction translation) cleared. All other bits pass unchanged. Without entry, `sr_o` and `dslot_o` copy `sr_i` and `dslot_i` one cycle later.
- R6: On entry, `npc_o` equals the cause index shifted left by 8. `cause_o` shows the index for that one cycle and returns to 0 (none) in the next cycle unless another entry occurs.
- R7: A synchronous request whose index is 0 or at least NUM_EXC (15) pulses `err_o` for one cycle. It produces no taken or flush pulse and leaves `epc_o`, `esr_o` and `npc_o` unchanged. Interrupts are not taken in that cycle.
- R8: An external interrupt (index 8) is taken only while SR bit 2 is set, and a tick interrupt (index 5) only while SR bit 1 is set. When both are pending and enabled, the tick is taken.
- R9: A synchronous request takes priority over any pending enabled interrupt in the same cycle.
- R10: Every entry pulses `taken_o` and `flush_o` together for exactly the cycle after the accepting edge. They are low in cycles without entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | AW | Current program counter |
| dslot_i | input | 1 | Current instruction is in a delay slot |
| sr_i | input | SRW | Current supervision register |
| sync_req_i | input | 1 | Synchronous exception request |
| sync_idx_i | input | IDXW | Index of the synchronous exception |
| ext_irq_i | input | 1 | External interrupt level |
| tick_irq_i | input | 1 | Tick timer interrupt level |
| epc_o | output | AW | Saved exception PC |
| esr_o | output | SRW | Saved supervision register |
| sr_o | output | SRW | Next supervision register |
| dslot_o | output | 1 | Next delay-slot flag |
| npc_o | output | AW | Handler address |
| cause_o | output | IDXW | Cause of the last entry, 0 when none |
| taken_o | output | 1 | Entry strobe |
| flush_o | output | 1 | Translation-cache flush strobe |
| err_o | output | 1 | Invalid synchronous index |

## Verification
The hardest cases to reach are where the adjustment rules and priorities overlap. Examples are a system call raised in a delay slot, which must save the unmodified PC, and a delay-slot entry at PC 0, where the subtraction must wrap. Other cases are an invalid synchronous index arriving while both interrupt lines are pending and enabled, and a tick and an external request that are both pending while only one enable bit is set. Directed steps set up each of these combinations explicitly. A long run of biased random vectors then mixes delay slots, enable bits and index values at and around the valid range boundaries. A behavioural model checks every output on every cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int SR_SM  = 0;
  localparam int SR_TEE = 1;
  localparam int SR_IEE = 2;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_DSX = 13;

  localparam int EXC_TICK    = 5;
  localparam int EXC_EXT     = 8;
  localparam int EXC_SYSCALL = 12;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int IDXW    = 5,
  parameter int NUM_EXC = 15
) (
  input  logic            sync_req_i,
  input  logic [IDXW-1:0] sync_idx_i,
  input  logic            ext_irq_i,
  input  logic            tick_irq_i,
  input  logic            iee_i,
  input  logic            tee_i,
  output logic            take_o,
  output logic [IDXW-1:0] idx_o,
  output logic            err_o
);
  import exc_entry_pkg::*;

  localparam logic [IDXW:0] NUM_L = (IDXW+1)'(NUM_EXC);

  logic idx_ok;
  assign idx_ok = (sync_idx_i != '0) && ({1'b0, sync_idx_i} < NUM_L);

  always_comb begin
    take_o = 1'b0;
    err_o  = 1'b0;
    idx_o  = '0;
    if (sync_req_i) begin
      // synchronous request owns the cycle, valid or not
      take_o = idx_ok;
      err_o  = !idx_ok;
      idx_o  = idx_ok ? sync_idx_i : '0;
    end else if (tick_irq_i && tee_i) begin
      take_o = 1'b1;
      idx_o  = IDXW'(EXC_TICK);
    end else if (ext_irq_i && iee_i) begin
      take_o = 1'b1;
      idx_o  = IDXW'(EXC_EXT);
    end
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int AW         = 32,
  parameter int IDXW       = 5,
  parameter int SLOT_BYTES = 4
) (
  input  logic [AW-1:0]   pc_i,
  input  logic            dslot_i,
  input  logic [IDXW-1:0] idx_i,
  output logic [AW-1:0]   epc_o
);
  import exc_entry_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(SLOT_BYTES);

  logic [AW-1:0] back;
  assign back  = dslot_i ? pc_i - STEP : pc_i;
  assign epc_o = (idx_i == IDXW'(EXC_SYSCALL)) ? back + STEP : back;
endmodule

// File: rtl/exc_sr_calc.sv
module exc_sr_calc #(
  parameter int SRW = 16
) (
  input  logic [SRW-1:0] sr_i,
  input  logic           dslot_i,
  output logic [SRW-1:0] sr_o
);
  import exc_entry_pkg::*;

  always_comb begin
    sr_o         = sr_i;
    sr_o[SR_SM]  = 1'b1;
    sr_o[SR_TEE] = 1'b0;
    sr_o[SR_IEE] = 1'b0;
    sr_o[SR_DME] = 1'b0;
    sr_o[SR_IME] = 1'b0;
    if (dslot_i) sr_o[SR_DSX] = 1'b1;
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int AW         = 32,
  parameter int SRW        = 16,
  parameter int IDXW       = 5,
  parameter int NUM_EXC    = 15,
  parameter int VEC_SHIFT  = 8,
  parameter int SLOT_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   pc_i,
  input  logic            dslot_i,
  input  logic [SRW-1:0]  sr_i,
  input  logic            sync_req_i,
  input  logic [IDXW-1:0] sync_idx_i,
  input  logic            ext_irq_i,
  input  logic            tick_irq_i,
  output logic [AW-1:0]   epc_o,
  output logic [SRW-1:0]  esr_o,
  output logic [SRW-1:0]  sr_o,
  output logic            dslot_o,
  output logic [AW-1:0]   npc_o,
  output logic [IDXW-1:0] cause_o,
  output logic            taken_o,
  output logic            flush_o,
  output logic            err_o
);
  import exc_entry_pkg::*;

  logic            take, bad;
  logic [IDXW-1:0] idx;
  logic [AW-1:0]   epc_d;
  logic [SRW-1:0]  sr_d;

  exc_arbiter #(.IDXW(IDXW), .NUM_EXC(NUM_EXC)) u_arb (
    .sync_req_i (sync_req_i),
    .sync_idx_i (sync_idx_i),
    .ext_irq_i  (ext_irq_i),
    .tick_irq_i (tick_irq_i),
    .iee_i      (sr_i[SR_IEE]),
    .tee_i      (sr_i[SR_TEE]),
    .take_o     (take),
    .idx_o      (idx),
    .err_o      (bad)
  );

  exc_epc_calc #(.AW(AW), .IDXW(IDXW), .SLOT_BYTES(SLOT_BYTES)) u_epc (
    .pc_i    (pc_i),
    .dslot_i (dslot_i),
    .idx_i   (idx),
    .epc_o   (epc_d)
  );

  exc_sr_calc #(.SRW(SRW)) u_sr (
    .sr_i    (sr_i),
    .dslot_i (dslot_i),
    .sr_o    (sr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      esr_o   <= '0;
      sr_o    <= '0;
      dslot_o <= 1'b0;
      npc_o   <= '0;
      cause_o <= '0;
      taken_o <= 1'b0;
      flush_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      taken_o <= take;
      flush_o <= take;
      err_o   <= bad;
      if (take) begin
        epc_o   <= epc_d;
        esr_o   <= sr_i;
        sr_o    <= sr_d;
        dslot_o <= 1'b0;
        npc_o   <= AW'(idx) << VEC_SHIFT;
        cause_o <= idx;
      end else begin
        sr_o    <= sr_i;
        dslot_o <= dslot_i;
        cause_o <= '0;
      end
    end
  end

  AST_EPC_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && !$past(dslot_i) && cause_o != IDXW'(EXC_SYSCALL) |-> epc_o == $past(pc_i)); // R1
  AST_DSLOT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && $past(dslot_i) |-> sr_o[SR_DSX] && !dslot_o); // R2
  AST_SYSCALL_DSLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o && $past(dslot_i) && cause_o == IDXW'(EXC_SYSCALL) |-> epc_o == $past(pc_i)); // R3
  AST_ESR_SNAPSHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> esr_o == $past(sr_i)); // R4
  AST_SR_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> sr_o[SR_SM] && !sr_o[SR_TEE] && !sr_o[SR_IEE] && !sr_o[SR_DME] && !sr_o[SR_IME]); // R5
  AST_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> npc_o == (AW'(cause_o) << VEC_SHIFT) && cause_o != '0); // R6
  AST_ERR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !taken_o && $stable(epc_o) && $stable(esr_o) && $stable(npc_o)); // R7
  AST_TICK_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sync_req_i && tick_irq_i && sr_i[SR_TEE]) |-> taken_o && cause_o == IDXW'(EXC_TICK)); // R8
  AST_SYNC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_req_i) |-> cause_o == ($past(sync_idx_i) & {IDXW{taken_o}})); // R9
  AST_FLUSH_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o == taken_o); // R10
endmodule

// File: tb/exc_entry_test.sv
module exc_entry_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0;
  logic        dslot_i = 1'b0;
  logic [15:0] sr_i = '0;
  logic        sync_req_i = 1'b0;
  logic [4:0]  sync_idx_i = '0;
  logic        ext_irq_i = 1'b0;
  logic        tick_irq_i = 1'b0;
  logic [31:0] epc_o, npc_o;
  logic [15:0] esr_o, sr_o;
  logic        dslot_o, taken_o, flush_o, err_o;
  logic [4:0]  cause_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_epc = 0, m_npc = 0;
  logic [15:0] m_esr = 0, m_sr = 0;
  logic        m_dslot = 0, m_taken = 0, m_flush = 0, m_err = 0;
  logic [4:0]  m_cause = 0;

  always #2 clk_i = ~clk_i;

  exc_entry uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .dslot_i(dslot_i), .sr_i(sr_i),
    .sync_req_i(sync_req_i), .sync_idx_i(sync_idx_i), .ext_irq_i(ext_irq_i),
    .tick_irq_i(tick_irq_i), .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o),
    .dslot_o(dslot_o), .npc_o(npc_o), .cause_o(cause_o), .taken_o(taken_o),
    .flush_o(flush_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "epc_o", epc_o, m_epc);
    chk("R4", "esr_o", 32'(esr_o), 32'(m_esr));
    chk("R5", "sr_o", 32'(sr_o), 32'(m_sr));
    chk("R2", "dslot_o", 32'(dslot_o), 32'(m_dslot));
    chk("R6", "npc_o", npc_o, m_npc);
    chk("R6", "cause_o", 32'(cause_o), 32'(m_cause));
    chk("R10", "taken_o", 32'(taken_o), 32'(m_taken));
    chk("R10", "flush_o", 32'(flush_o), 32'(m_flush));
    chk("R7", "err_o", 32'(err_o), 32'(m_err));
  endtask

  // drive one vector, let it cross one edge, update model, compare
  task automatic step(input logic rq, input logic [4:0] ix, input logic [31:0] pc,
                      input logic ds, input logic [15:0] sr, input logic ext, input logic tick);
    int sel;
    bit er;
    sync_req_i = rq; sync_idx_i = ix; pc_i = pc; dslot_i = ds;
    sr_i = sr; ext_irq_i = ext; tick_irq_i = tick;
    @(posedge clk_i);
    #1;
    sel = -1; er = 0;
    if (rq) begin
      if (ix > 0 && ix < 15) sel = int'(ix); else er = 1;   // R7, R9
    end else if (tick && sr[1]) sel = 5;                  // R8
    else if (ext && sr[2]) sel = 8;
    m_err = er;
    m_taken = (sel >= 0);
    m_flush = m_taken;
    if (sel >= 0) begin
      m_epc = pc;
      if (ds) m_epc = m_epc - 4;                           // R2
      if (sel == 12) m_epc = m_epc + 4;                    // R3
      m_esr = sr;
      m_sr = sr;
      m_sr[0] = 1; m_sr[1] = 0; m_sr[2] = 0; m_sr[5] = 0; m_sr[6] = 0;
      if (ds) m_sr[13] = 1;
      m_npc = 32'(sel) * 256;
      m_cause = 5'(sel);
      m_dslot = 0;
    end else begin
      m_sr = sr;
      m_dslot = ds;
      m_cause = 0;
    end
    compare_all();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    compare_all();                                   // reset state
    rst_ni = 1'b1;
    step(0, 0, 32'h1000, 0, 16'h0000, 1, 1);         // R8 nothing enabled
    step(0, 0, 32'h1004, 1, 16'h8010, 0, 0);         // R5 pass-through with dslot
    step(0, 0, 32'h2000, 0, 16'h0004, 1, 0);         // R8 external -> 0x800
    step(0, 0, 32'h2004, 0, 16'h0006, 1, 1);         // R8 tick wins
    step(0, 0, 32'h2008, 0, 16'h0004, 1, 1);         // R8 tick disabled, ext taken
    step(0, 0, 32'h200c, 0, 16'h0002, 1, 0);         // R8 ext disabled
    step(1, 5'd12, 32'h3000, 0, 16'hffff, 0, 0);     // R3 syscall no dslot
    step(1, 5'd12, 32'h3100, 1, 16'h0066, 1, 1);     // R3 R9 syscall in dslot
    step(1, 5'd3, 32'h0000, 1, 16'h0001, 0, 0);      // R2 wrap
    step(1, 5'd0, 32'h4000, 0, 16'h0006, 1, 1);      // R7 index 0, irqs blocked
    step(1, 5'd15, 32'h4004, 1, 16'h0006, 1, 1);     // R7 index NUM_EXC
    step(1, 5'd31, 32'h4008, 0, 16'h0000, 0, 0);     // R7 max index
    step(1, 5'd14, 32'h400c, 0, 16'h2000, 0, 0);     // R6 top valid index
    step(1, 5'd1, 32'h4010, 0, 16'h0000, 0, 0);      // R6 lowest valid
    step(0, 0, 32'h4014, 0, 16'h0000, 0, 0);         // R6 cause back to none
    step(0, 0, 32'h4018, 0, 16'h0006, 1, 1);         // R10 back-to-back entries
    step(0, 0, 32'h401c, 0, 16'h0006, 1, 1);
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] ix;
      ix = 5'($urandom_range(0, 17));
      if (($urandom & 7) == 0) ix = 5'($urandom);
      step(($urandom % 3) == 0, ix, $urandom & 32'hfffffffc, $urandom % 2,
           16'($urandom), $urandom % 2, $urandom % 2);
    end
    rst_ni = 1'b0;
    #1;
    m_epc = 0; m_npc = 0; m_esr = 0; m_sr = 0; m_dslot = 0;
    m_taken = 0; m_flush = 0; m_err = 0; m_cause = 0;
    compare_all();                                   // async reset clears all
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule